// File: doc/BRIEF.md
# Cartridge Bank-Switching Memory Mapper

This block sits between a game console's 8-bit CPU and picture buses and the memories on a cartridge. It turns each bus address into a physical address in program ROM, in work RAM or in character memory. It also raises the chip select for the memory that should answer, and it reports how the nametables are mirrored. The block holds no memory arrays of its own.

Software programs the mapper indirectly. A write to the 0x8000–0x9FFF window picks a command index, and a later write to 0xA000–0xBFFF stores a byte into the register that index names. There are eight 1 KB character page registers, four 8 KB program bank registers and a two-bit mirroring mode. The 0x6000–0x7FFF window can be switched between ROM and RAM by two flag bits. The top window always shows the last program bank. Writes in 0xC000–0xDFFF and 0xE000–0xFFFF are passed on, with their data, as address and data strobes for an external sound device.

Bank numbers are reduced to the implemented bank counts by masking. All counts are parameters that must be powers of two. A further parameter states whether character memory is writable.

Top module: `cart_bank_mapper`

## Requirements
- R1: A CPU write (cpu_req=1, cpu_we=1) in 0x8000–0x9FFF latches cpu_wdata[3:0] as the command index, ignoring bits 7:4. A write in 0xA000–0xBFFF stores cpu_wdata into the register that index selects. Command indexes 0xD, 0xE and 0xF select no register, and a write to them changes no output.
- R2: Commands 0 to 7 load the character page for slot 0 to 7. A picture-bus access drives chr_addr = {page mod CHR_BANKS, ppu_addr[9:0]}, where the slot is ppu_addr[12:10].
- R3: Commands 9, 0xA and 0xB set the banks of the 0x8000, 0xA000 and 0xC000 windows. A read there drives prg_rom_addr = (bank mod PRG_BANKS)·8192 + cpu_addr[12:0] with prg_rom_cs=1.
- R4: A read in 0xE000–0xFFFF always maps bank PRG_BANKS−1.
- R5: Command 8 sets the low-window register. When its bits 7 and 6 are not both 1, a read in 0x6000–0x7FFF maps ROM bank (bits 5:0 mod PRG_BANKS). prg_rom_cs is asserted only for reads in 0x6000–0xFFFF.
- R6: When bits 7 and 6 of the low-window register are both 1 and bits 5:0 give a bank below WRAM_BANKS, an access to 0x6000–0x7FFF asserts wram_cs with wram_addr = bank·8192 + cpu_addr[12:0]. wram_we is also asserted on writes.
- R7: In RAM mode with a bank of WRAM_BANKS or above, a read asserts open_bus_en with open_bus_data = cpu_addr[15:8]. wram_cs stays low.
- R8: A write in 0x6000–0x7FFF asserts wram_we only in the RAM mode of R6. Otherwise it selects nothing.
- R9: Command 0xC sets mirror_mode from cpu_wdata[1:0]: 0 vertical, 1 horizontal, 2 single-screen page 0, 3 single-screen page 1.
- R10: After reset the command index is 0, the low-window and 0x8000 banks are 0, the 0xA000 bank is 1, the 0xC000 bank is 2, every character page is 0 and mirror_mode is 0.
- R11: A write in 0xC000–0xDFFF asserts snd_addr_stb and a write in 0xE000–0xFFFF asserts snd_data_stb, each in the same cycle and with snd_data = cpu_wdata. Neither write asserts a memory select.
- R12: A picture-bus write asserts chr_we and chr_cs only when CHR_IS_RAM=1. With CHR_IS_RAM=0 both stay low on writes.
- R13: A CPU access below 0x6000 asserts no select, strobe or open-bus output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | CPU access in this cycle |
| cpu_we | input | 1 | CPU access is a write |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| ppu_req | input | 1 | Picture-bus access in this cycle |
| ppu_we | input | 1 | Picture-bus access is a write |
| ppu_addr | input | 13 | Picture-bus pattern address |
| prg_rom_addr | output | PRG_AW | Physical program ROM address |
| prg_rom_cs | output | 1 | Program ROM select (reads) |
| wram_addr | output | WRAM_AW | Physical work RAM address |
| wram_cs | output | 1 | Work RAM select |
| wram_we | output | 1 | Work RAM write enable |
| open_bus_en | output | 1 | Drive open-bus value on the read |
| open_bus_data | output | 8 | Open-bus value (address high byte) |
| chr_addr | output | CHR_AW | Physical character memory address |
| chr_cs | output | 1 | Character memory select |
| chr_we | output | 1 | Character memory write enable |
| mirror_mode | output | 2 | Nametable mirroring code |
| snd_addr_stb | output | 1 | Sound device register-address strobe |
| snd_data_stb | output | 1 | Sound device data strobe |
| snd_data | output | 8 | Data for the sound device |

## Verification
The assertions assume cpu_we and ppu_we are meaningful only while the matching request is high. They also assume that a write is held for a single cycle, so that each register write is seen once. The stimulus opens every access at a falling edge and drops a write right after the next rising edge, so no write repeats. Sweeps run a small configuration with 8 program banks, 16 character pages and 2 RAM banks. Every register value 0–255 is therefore tried, covering out-of-range banks and all ROM/RAM flag combinations. A second instance differs only in CHR_IS_RAM.

// File: rtl/mapper_pkg.sv
`timescale 1ns/1ps
package mapper_pkg;
   typedef enum logic [1:0] {
      MIR_VERT   = 2'd0,
      MIR_HORIZ  = 2'd1,
      MIR_ONE_LO = 2'd2,
      MIR_ONE_HI = 2'd3
   } mirror_e;

   localparam logic [3:0] CMD_LOW_WIN = 4'h8;
   localparam logic [3:0] CMD_WIN_8   = 4'h9;
   localparam logic [3:0] CMD_WIN_A   = 4'hA;
   localparam logic [3:0] CMD_WIN_C   = 4'hB;
   localparam logic [3:0] CMD_MIRROR  = 4'hC;

   localparam logic [2:0] WIN_LOW  = 3'd3;
   localparam logic [2:0] WIN_CMD  = 3'd4;
   localparam logic [2:0] WIN_ARG  = 3'd5;
   localparam logic [2:0] WIN_SNDA = 3'd6;
   localparam logic [2:0] WIN_SNDD = 3'd7;
endpackage

// File: rtl/mapper_cmd_regs.sv
`timescale 1ns/1ps
module mapper_cmd_regs
   import mapper_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cmd_wr,
   input  logic            arg_wr,
   input  logic [7:0]      wdata,
   output logic [7:0][7:0] chr_bank_q,
   output logic [3:0][7:0] prg_bank_q,
   output mirror_e         mirror_q
);
   logic [3:0] cmd_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q      <= '0;
         chr_bank_q <= '0;
         prg_bank_q <= {8'd2, 8'd1, 8'd0, 8'd0};
         mirror_q   <= MIR_VERT;
      end else begin
         if (cmd_wr) cmd_q <= wdata[3:0];
         if (arg_wr) begin
            if (!cmd_q[3]) begin
               chr_bank_q[cmd_q[2:0]] <= wdata;
            end else begin
               case (cmd_q)
                  CMD_LOW_WIN: prg_bank_q[0] <= wdata;
                  CMD_WIN_8:   prg_bank_q[1] <= wdata;
                  CMD_WIN_A:   prg_bank_q[2] <= wdata;
                  CMD_WIN_C:   prg_bank_q[3] <= wdata;
                  CMD_MIRROR:  mirror_q      <= mirror_e'(wdata[1:0]);
                  default:     ;
               endcase
            end
         end
      end
   end

   AST_CMD_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_wr |=> cmd_q == $past(wdata[3:0])) else $error("command latch"); // R1
   AST_MIRROR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(arg_wr && cmd_q == CMD_MIRROR) |=> $stable(mirror_q)) else $error("mirror moved"); // R9
   AST_HIGH_CMD_INERT: assert property (@(posedge clk) disable iff (!rst_n)
      (arg_wr && cmd_q > CMD_MIRROR) |=> $stable(prg_bank_q) && $stable(chr_bank_q)) else $error("inert cmd wrote"); // R1
endmodule

// File: rtl/mapper_cpu_decode.sv
`timescale 1ns/1ps
module mapper_cpu_decode
   import mapper_pkg::*;
#(
   parameter int PRG_BANKS  = 256,
   parameter int WRAM_BANKS = 1,
   localparam int PB_W      = $clog2(PRG_BANKS),
   localparam int PRG_AW    = PB_W + 13,
   localparam int WRAM_AW   = $clog2(WRAM_BANKS) + 13
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cpu_req,
   input  logic               cpu_we,
   input  logic [15:0]        cpu_addr,
   input  logic [7:0]         cpu_wdata,
   input  logic [3:0][7:0]    prg_bank_q,
   output logic [PRG_AW-1:0]  rom_addr,
   output logic               rom_cs,
   output logic [WRAM_AW-1:0] wram_addr,
   output logic               wram_cs,
   output logic               wram_we,
   output logic               open_bus_en,
   output logic [7:0]         open_bus_data,
   output logic               snd_addr_stb,
   output logic               snd_data_stb,
   output logic [7:0]         snd_data
);
   logic [2:0]  win;
   logic [12:0] off;
   logic [7:0]  low_sel;
   logic [7:0]  sel_bank;
   logic        ram_mode;
   logic        ram_in_range;
   logic        is_low;

   assign win     = cpu_addr[15:13];
   assign off     = cpu_addr[12:0];
   assign low_sel = prg_bank_q[0];

   generate
      if (WRAM_BANKS == 1) begin : g_wram_single
         assign ram_in_range = (low_sel[5:0] == 6'd0);
         assign wram_addr    = off;
      end else begin : g_wram_multi
         localparam int WB_W = $clog2(WRAM_BANKS);
         localparam logic [6:0] WRAM_LIM = 7'(WRAM_BANKS);
         assign ram_in_range = ({1'b0, low_sel[5:0]} < WRAM_LIM);
         assign wram_addr    = {low_sel[WB_W-1:0], off};
      end
   endgenerate

   always_comb begin
      case (win)
         WIN_LOW:  sel_bank = {2'b00, low_sel[5:0]};
         WIN_CMD:  sel_bank = prg_bank_q[1];
         WIN_ARG:  sel_bank = prg_bank_q[2];
         WIN_SNDA: sel_bank = prg_bank_q[3];
         default:  sel_bank = 8'hFF;
      endcase
      is_low        = (win == WIN_LOW);
      ram_mode      = low_sel[7] & low_sel[6];
      rom_addr      = {sel_bank[PB_W-1:0], off};
      rom_cs        = cpu_req & ~cpu_we & ((is_low & ~ram_mode) | win[2]);
      wram_cs       = cpu_req & is_low & ram_mode & ram_in_range;
      wram_we       = wram_cs & cpu_we;
      open_bus_en   = cpu_req & ~cpu_we & is_low & ram_mode & ~ram_in_range;
      open_bus_data = cpu_addr[15:8];
      snd_addr_stb  = cpu_req & cpu_we & (win == WIN_SNDA);
      snd_data_stb  = cpu_req & cpu_we & (win == WIN_SNDD);
      snd_data      = cpu_wdata;
   end

   AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rom_cs, wram_cs, open_bus_en, snd_addr_stb, snd_data_stb})) else $error("two targets"); // R5
   AST_TOP_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
      (rom_cs && cpu_addr[15:13] == 3'd7) |-> &rom_addr[PRG_AW-1:13]) else $error("top window moved"); // R4
   AST_RAM_WRITE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      wram_we |-> (cpu_req && cpu_we && cpu_addr[15:13] == 3'd3 && prg_bank_q[0][7:6] == 2'b11)) else $error("stray RAM write"); // R8
   AST_OPEN_BUS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      open_bus_en |-> (open_bus_data == cpu_addr[15:8] && !wram_cs)) else $error("open bus"); // R7
   AST_LOW_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_addr < 16'h6000) |-> !(rom_cs || wram_cs || open_bus_en || snd_addr_stb || snd_data_stb)) else $error("low select"); // R13
endmodule

// File: rtl/mapper_chr_decode.sv
`timescale 1ns/1ps
module mapper_chr_decode #(
   parameter int CHR_BANKS  = 256,
   parameter bit CHR_IS_RAM = 1'b0,
   localparam int CB_W      = $clog2(CHR_BANKS),
   localparam int CHR_AW    = CB_W + 10
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ppu_req,
   input  logic              ppu_we,
   input  logic [12:0]       ppu_addr,
   input  logic [7:0][7:0]   chr_bank_q,
   output logic [CHR_AW-1:0] chr_addr,
   output logic              chr_cs,
   output logic              chr_we
);
   logic [7:0] page;

   assign page     = chr_bank_q[ppu_addr[12:10]];
   assign chr_addr = {page[CB_W-1:0], ppu_addr[9:0]};

   generate
      if (CHR_IS_RAM) begin : g_chr_ram
         assign chr_cs = ppu_req;
         assign chr_we = ppu_req & ppu_we;
      end else begin : g_chr_rom
         assign chr_cs = ppu_req & ~ppu_we;
         assign chr_we = 1'b0;
      end
   endgenerate

   AST_CHR_WRITE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      chr_we |-> (ppu_req && ppu_we && chr_cs)) else $error("chr write source"); // R12
endmodule

// File: rtl/cart_bank_mapper.sv
`timescale 1ns/1ps
module cart_bank_mapper
   import mapper_pkg::*;
#(
   parameter int PRG_BANKS  = 256,
   parameter int CHR_BANKS  = 256,
   parameter int WRAM_BANKS = 1,
   parameter bit CHR_IS_RAM = 1'b0,
   localparam int PRG_AW    = $clog2(PRG_BANKS) + 13,
   localparam int CHR_AW    = $clog2(CHR_BANKS) + 10,
   localparam int WRAM_AW   = $clog2(WRAM_BANKS) + 13
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cpu_req,
   input  logic               cpu_we,
   input  logic [15:0]        cpu_addr,
   input  logic [7:0]         cpu_wdata,
   input  logic               ppu_req,
   input  logic               ppu_we,
   input  logic [12:0]        ppu_addr,
   output logic [PRG_AW-1:0]  prg_rom_addr,
   output logic               prg_rom_cs,
   output logic [WRAM_AW-1:0] wram_addr,
   output logic               wram_cs,
   output logic               wram_we,
   output logic               open_bus_en,
   output logic [7:0]         open_bus_data,
   output logic [CHR_AW-1:0]  chr_addr,
   output logic               chr_cs,
   output logic               chr_we,
   output logic [1:0]         mirror_mode,
   output logic               snd_addr_stb,
   output logic               snd_data_stb,
   output logic [7:0]         snd_data
);
   generate
      if (PRG_BANKS < 2 || PRG_BANKS > 256 || (PRG_BANKS & (PRG_BANKS - 1)) != 0) begin : g_bad_prg
         $error("PRG_BANKS must be a power of two in 2..256");
      end
      if (CHR_BANKS < 2 || CHR_BANKS > 256 || (CHR_BANKS & (CHR_BANKS - 1)) != 0) begin : g_bad_chr
         $error("CHR_BANKS must be a power of two in 2..256");
      end
      if (WRAM_BANKS < 1 || WRAM_BANKS > 64 || (WRAM_BANKS & (WRAM_BANKS - 1)) != 0) begin : g_bad_wram
         $error("WRAM_BANKS must be a power of two in 1..64");
      end
   endgenerate

   logic [7:0][7:0] chr_bank_q;
   logic [3:0][7:0] prg_bank_q;
   mirror_e         mirror_q;
   logic            cmd_wr;
   logic            arg_wr;

   assign cmd_wr      = cpu_req & cpu_we & (cpu_addr[15:13] == WIN_CMD);
   assign arg_wr      = cpu_req & cpu_we & (cpu_addr[15:13] == WIN_ARG);
   assign mirror_mode = mirror_q;

   mapper_cmd_regs u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_wr     (cmd_wr),
      .arg_wr     (arg_wr),
      .wdata      (cpu_wdata),
      .chr_bank_q (chr_bank_q),
      .prg_bank_q (prg_bank_q),
      .mirror_q   (mirror_q)
   );

   mapper_cpu_decode #(.PRG_BANKS(PRG_BANKS), .WRAM_BANKS(WRAM_BANKS)) u_cpu (
      .clk           (clk),
      .rst_n         (rst_n),
      .cpu_req       (cpu_req),
      .cpu_we        (cpu_we),
      .cpu_addr      (cpu_addr),
      .cpu_wdata     (cpu_wdata),
      .prg_bank_q    (prg_bank_q),
      .rom_addr      (prg_rom_addr),
      .rom_cs        (prg_rom_cs),
      .wram_addr     (wram_addr),
      .wram_cs       (wram_cs),
      .wram_we       (wram_we),
      .open_bus_en   (open_bus_en),
      .open_bus_data (open_bus_data),
      .snd_addr_stb  (snd_addr_stb),
      .snd_data_stb  (snd_data_stb),
      .snd_data      (snd_data)
   );

   mapper_chr_decode #(.CHR_BANKS(CHR_BANKS), .CHR_IS_RAM(CHR_IS_RAM)) u_chr (
      .clk        (clk),
      .rst_n      (rst_n),
      .ppu_req    (ppu_req),
      .ppu_we     (ppu_we),
      .ppu_addr   (ppu_addr),
      .chr_bank_q (chr_bank_q),
      .chr_addr   (chr_addr),
      .chr_cs     (chr_cs),
      .chr_we     (chr_we)
   );
endmodule

// File: tb/tb_cart_bank_mapper.sv
`timescale 1ns/1ps
module tb_cart_bank_mapper;
   localparam int NP = 8, NC = 16, NW = 2;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        cpu_req = 0, cpu_we = 0, ppu_req = 0, ppu_we = 0;
   logic [15:0] cpu_addr = '0;
   logic [7:0]  cpu_wdata = '0;
   logic [12:0] ppu_addr = '0;

   logic [15:0] prg_rom_addr;
   logic [13:0] wram_addr, chr_addr, chr_addr_r;
   logic        prg_rom_cs, wram_cs, wram_we, open_bus_en, chr_cs, chr_we;
   logic        chr_cs_r, chr_we_r, snd_addr_stb, snd_data_stb;
   logic [7:0]  open_bus_data, snd_data;
   logic [1:0]  mirror_mode;
   logic [15:0] p_a1;  logic [13:0] w_a1;  logic p1, w1, we1, ob1, sa1, sd1;
   logic [7:0]  ob_d1, sdat1;  logic [1:0] m1;

   int n_chk = 0, n_fail = 0;

   always #4 clk = ~clk;

   cart_bank_mapper #(.PRG_BANKS(NP), .CHR_BANKS(NC), .WRAM_BANKS(NW), .CHR_IS_RAM(1'b0)) dut (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .ppu_req(ppu_req), .ppu_we(ppu_we), .ppu_addr(ppu_addr),
      .prg_rom_addr(prg_rom_addr), .prg_rom_cs(prg_rom_cs), .wram_addr(wram_addr),
      .wram_cs(wram_cs), .wram_we(wram_we), .open_bus_en(open_bus_en),
      .open_bus_data(open_bus_data), .chr_addr(chr_addr), .chr_cs(chr_cs), .chr_we(chr_we),
      .mirror_mode(mirror_mode), .snd_addr_stb(snd_addr_stb), .snd_data_stb(snd_data_stb),
      .snd_data(snd_data));

   cart_bank_mapper #(.PRG_BANKS(NP), .CHR_BANKS(NC), .WRAM_BANKS(NW), .CHR_IS_RAM(1'b1)) dut_chrram (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .ppu_req(ppu_req), .ppu_we(ppu_we), .ppu_addr(ppu_addr),
      .prg_rom_addr(p_a1), .prg_rom_cs(p1), .wram_addr(w_a1), .wram_cs(w1), .wram_we(we1),
      .open_bus_en(ob1), .open_bus_data(ob_d1), .chr_addr(chr_addr_r), .chr_cs(chr_cs_r),
      .chr_we(chr_we_r), .mirror_mode(m1), .snd_addr_stb(sa1), .snd_data_stb(sd1), .snd_data(sdat1));

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic cpu_drive(input logic we, input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
      #1;
   endtask

   task automatic cpu_end();
      @(posedge clk); #1;
      cpu_req = 0; cpu_we = 0;
   endtask

   task automatic cpu_wr(input logic [15:0] a, input logic [7:0] d);
      cpu_drive(1'b1, a, d);
      cpu_end();
   endtask

   task automatic set_reg(input logic [3:0] c, input logic [7:0] d);
      cpu_wr(16'h8000, {4'h0, c});
      cpu_wr(16'hA000, d);
   endtask

   task automatic ppu_drive(input logic we, input logic [12:0] a);
      @(negedge clk);
      ppu_req = 1; ppu_we = we; ppu_addr = a;
      #1;
   endtask

   function automatic int rom_exp(input int bank, input int off);
      return (bank % NP) * 8192 + off;
   endfunction

   task automatic chk_rom(input logic [15:0] a, input int bank, input string tag);
      cpu_drive(1'b0, a, 8'h00);
      chk(prg_rom_cs && prg_rom_addr == 16'(rom_exp(bank, a[12:0])), tag,
          {prg_rom_cs, prg_rom_addr}, {1'b1, 16'(rom_exp(bank, a[12:0]))});
   endtask

   task automatic run_tests();
      // reset values, R10
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1;
      chk(mirror_mode == 2'd0, "R10 mirror", mirror_mode, 0);
      chk_rom(16'h8123, 0, "R10 bank 8000");
      chk_rom(16'hA456, 1, "R10 bank A000");
      chk_rom(16'hC789, 2, "R10 bank C000");
      chk_rom(16'h6ABC, 0, "R10 bank 6000 rom");
      ppu_drive(1'b0, 13'h0C55);
      chk(chr_addr == 14'h0055 && chr_cs, "R10 chr page", chr_addr, 14'h0055);
      // command index 0 after reset: argument goes to slot 0, R1 / R10
      cpu_wr(16'hA000, 8'd5);
      ppu_drive(1'b0, 13'h0123);
      chk(chr_addr == 14'(5 * 1024 + 'h123), "R1 slot0 via reset cmd", chr_addr, 5 * 1024 + 'h123);

      // character pages, R2
      for (int s = 0; s < 8; s++) set_reg(4'(s), 8'((s * 37 + 5) & 255));
      for (int s = 0; s < 8; s++) begin
         int off = (s * 131) & 1023;
         int e = (((s * 37 + 5) & 255) % NC) * 1024 + off;
         ppu_drive(1'b0, 13'(s * 1024 + off));
         chk(chr_addr == 14'(e), "R2 chr slot", chr_addr, e);
      end

      // switchable windows, R3, and fixed top, R4
      for (int w = 1; w < 4; w++) begin
         cpu_wr(16'h8000, 8'(8 + w));
         for (int v = 0; v < 256; v++) begin
            logic [15:0] a = 16'(16'h6000 + w * 16'h2000 + ((v * 53) & 16'h1FFF));
            cpu_wr(16'hA000, 8'(v));
            chk_rom(a, v, "R3 window bank");
         end
         chk_rom(16'hE000 + 16'(w * 321), NP - 1, "R4 top window");
      end
      chk_rom(16'hFFFF, NP - 1, "R4 top window end");

      // low window ROM / RAM / open bus, R5 R6 R7 R8
      cpu_wr(16'h8000, 8'h08);
      for (int v = 0; v < 256; v++) begin
         logic [15:0] a = 16'(16'h6000 + ((v * 97) & 16'h1FFF));
         bit ram = (v >= 192);
         int b = v & 63;
         bit hit = ram && (b < NW);
         cpu_wr(16'hA000, 8'(v));
         cpu_drive(1'b0, a, 8'h00);
         if (!ram)
            chk(prg_rom_cs && !wram_cs && !open_bus_en && prg_rom_addr == 16'(rom_exp(b, a[12:0])),
                "R5 low rom", prg_rom_addr, rom_exp(b, a[12:0]));
         else if (hit)
            chk(wram_cs && !wram_we && !prg_rom_cs && !open_bus_en && wram_addr == 14'(b * 8192 + a[12:0]),
                "R6 ram read", wram_addr, b * 8192 + a[12:0]);
         else
            chk(open_bus_en && !wram_cs && !prg_rom_cs && open_bus_data == a[15:8],
                "R7 open bus", {open_bus_en, open_bus_data}, {1'b1, a[15:8]});
         cpu_drive(1'b1, a, 8'h5A);
         chk(wram_we == hit && wram_cs == hit && !prg_rom_cs && !open_bus_en,
             "R8 low write", {wram_cs, wram_we, prg_rom_cs}, {hit, hit, 1'b0});
         if (hit) chk(wram_addr == 14'(b * 8192 + a[12:0]), "R6 ram write", wram_addr, b * 8192 + a[12:0]);
         cpu_end();
      end

      // mirroring, R9
      for (int m = 0; m < 4; m++) begin
         set_reg(4'hC, 8'(8'hA8 | m));
         @(negedge clk);
         chk(mirror_mode == 2'(m), "R9 mirror", mirror_mode, m);
      end

      // command latch width and inert commands, R1
      cpu_wr(16'h9FFF, 8'hF9);
      cpu_wr(16'hBFFF, 8'd3);
      chk_rom(16'h8010, 3, "R1 low nibble latch");
      for (int c = 13; c < 16; c++) set_reg(4'(c), 8'hFF);
      chk_rom(16'h8010, 3, "R1 inert cmd prg");
      chk(mirror_mode == 2'd3, "R1 inert cmd mirror", mirror_mode, 3);
      ppu_drive(1'b0, 13'h1400);
      chk(chr_addr == 14'(((5 * 37 + 5) % NC) * 1024), "R1 inert cmd chr", chr_addr, ((5 * 37 + 5) % NC) * 1024);

      // sound strobes, R11
      cpu_drive(1'b1, 16'hC123, 8'h3C);
      chk(snd_addr_stb && !snd_data_stb && snd_data == 8'h3C && !prg_rom_cs && !wram_cs,
          "R11 addr strobe", {snd_addr_stb, snd_data_stb, snd_data}, {2'b10, 8'h3C});
      cpu_end();
      cpu_drive(1'b1, 16'hE456, 8'hC3);
      chk(snd_data_stb && !snd_addr_stb && snd_data == 8'hC3 && !prg_rom_cs,
          "R11 data strobe", {snd_addr_stb, snd_data_stb, snd_data}, {2'b01, 8'hC3});
      cpu_end();
      chk_rom(16'hC000, 255, "R11 no register change");

      // character writes, R12
      ppu_drive(1'b1, 13'h0400);
      chk(!chr_we && !chr_cs, "R12 rom ignores write", {chr_cs, chr_we}, 0);
      chk(chr_we_r && chr_cs_r, "R12 ram forwards write", {chr_cs_r, chr_we_r}, 3);
      @(negedge clk); ppu_req = 0; ppu_we = 0;

      // below 0x6000, R13
      cpu_drive(1'b0, 16'h5FFF, 8'h00);
      chk(!(prg_rom_cs | wram_cs | open_bus_en), "R13 low read", {prg_rom_cs, wram_cs, open_bus_en}, 0);
      cpu_drive(1'b1, 16'h2000, 8'h77);
      chk(!(prg_rom_cs | wram_cs | wram_we | snd_addr_stb | snd_data_stb), "R13 low write",
          {prg_rom_cs, wram_cs, wram_we, snd_addr_stb, snd_data_stb}, 0);
      cpu_end();
   endtask

   initial begin
      fork
         run_tests();
         begin
            repeat (150000) @(posedge clk);
            chk(1'b0, "watchdog", 0, 1);
         end
      join_any
      disable fork;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule